// File: doc/BRIEF.md
# Oscillator Divider and Rate Selector

This block is the countdown chain that turns a 32.768 kHz time base into slower rates. Each pulse on `osc_tick` stands for one oscillator period; when the chain runs, a 15-stage binary counter advances by one per pulse. Stage k (bit k) then toggles at 32768 / 2^(k+1) Hz, and the last stage is a 1 Hz square wave.

A 3-bit control field drives a small state machine with three states. In `OSC_OFF` the oscillator is stopped and the chain keeps its value. In `CHAIN_HELD` the oscillator runs but the chain is forced to zero. In `CHAIN_RUN` the chain counts. The state is loaded from the decoded field on every clock, so any state can move to any other. These are the transitions: enter-run when the field is 010, enter-hold when the field is 11x, and stop for any other value.

A 4-bit rate code picks one tap through a 16-way multiplexer. The selected tap drives two outputs. The square-wave output shows the tap level when its enable is set. The periodic pulse marks each rising edge of the tap when its own enable is set. A separate one-second tick marks each rising edge of the last stage.

Top module: `osc_divider`

## Requirements
- R1: While `rst_n` is low, the state is `OSC_OFF`, the chain is zero, and `sq_out`, `pi_pulse` and `sec_tick` are low.
- R2: With `dv_ctl` = 3'b010 (the `CHAIN_RUN` state), the chain advances by exactly one for each clock on which `osc_tick` is high.
- R3: With `dv_ctl` = 3'b110 or 3'b111 (the `CHAIN_HELD` state), the chain is held at zero. No periodic pulse or tick occurs, and `sq_out` stays low.
- R4: Any other `dv_ctl` value (the `OSC_OFF` state) freezes the chain at its current value. No tap toggles and no pulse occurs. Returning to run resumes counting from the frozen value.
- R5: Rate codes 3 to 15 select chain bit (code − 2). Code 3 gives 8192 Hz (one event every 4 ticks), each higher code halves the rate, and code 15 gives 2 Hz (one event per 16384 ticks).
- R6: Rate code 1 selects bit 6 (256 Hz) and rate code 2 selects bit 7 (128 Hz).
- R7: Rate code 0 selects no tap: `sq_out` stays low and no periodic pulse occurs.
- R8: `sq_out` equals the selected tap level while `sq_en` is high and is low while `sq_en` is low.
- R9: When `pi_en` is high, `pi_pulse` is high for one clock, on the clock after the oscillator tick that gives the selected tap a rising edge. When `pi_en` is low, it never rises.
- R10: `sec_tick` is high for one clock after each rising edge of bit 14. The first one comes after exactly 16384 ticks once the chain is released from hold.
- R11: A change of `rate_sel` takes effect on the next clock and does not reset the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-clock enable per 32.768 kHz oscillator period |
| dv_ctl | input | 3 | Oscillator / chain control field |
| rate_sel | input | 4 | Tap select code for the multiplexer |
| sq_en | input | 1 | Square-wave output enable |
| pi_en | input | 1 | Periodic pulse enable |
| sq_out | output | 1 | Gated square wave from the selected tap |
| pi_pulse | output | 1 | One-clock pulse per rising edge of the selected tap |
| sec_tick | output | 1 | One-clock pulse per rising edge of the last stage |

## Verification
The assertions check on every cycle that the chain steps by exactly one in run and stays still when stopped. They also check that run and hold are never decoded together, that both pulse outputs last one clock, that the gates and code 0 block their outputs, and that a second tick coincides with a set top stage. The rate map itself can only be shown by the bench scenarios. These count events over known tick windows for the fast, middle and slowest codes. The same holds for the 16384-tick delay to the first second tick, for freezing and resuming through the stop state, and for changing the rate code mid-count without resetting the chain.

// File: rtl/osc_div_pkg.sv
`timescale 1ns/1ps
package osc_div_pkg;

    typedef enum logic [1:0] {
        OSC_OFF    = 2'd0,
        CHAIN_HELD = 2'd1,
        CHAIN_RUN  = 2'd2
    } osc_state_t;

endpackage

// File: rtl/osc_ctrl_fsm.sv
`timescale 1ns/1ps
module osc_ctrl_fsm
    import osc_div_pkg::*;
#(
    parameter int            DV_W      = 3,
    parameter logic [DV_W-1:0] RUN_PAT   = 3'b010,
    parameter logic [DV_W-1:0] HOLD_MASK = 3'b110,
    parameter logic [DV_W-1:0] HOLD_PAT  = 3'b110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DV_W-1:0] dv_ctl,
    output logic            run_en,
    output logic            hold_clr
);

    osc_state_t state_q;
    osc_state_t state_d;

    // next-state decode of the control field
    always_comb begin
        if (dv_ctl == RUN_PAT) begin
            state_d = CHAIN_RUN;
        end else if ((dv_ctl & HOLD_MASK) == HOLD_PAT) begin
            state_d = CHAIN_HELD;
        end else begin
            state_d = OSC_OFF;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of each state
    always_comb begin
        run_en   = 1'b0;
        hold_clr = 1'b0;
        unique case (state_q)
            OSC_OFF:    begin run_en = 1'b0; hold_clr = 1'b0; end
            CHAIN_HELD: begin run_en = 1'b0; hold_clr = 1'b1; end
            CHAIN_RUN:  begin run_en = 1'b1; hold_clr = 1'b0; end
            default:    begin run_en = 1'b0; hold_clr = 1'b0; end
        endcase
    end

    // R2 / R3: run and hold are never active together
    p_run_hold_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_en, hold_clr}));

    // R3: a hold pattern reaches the hold state one clock later
    p_hold_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((dv_ctl & HOLD_MASK) == HOLD_PAT) |=> hold_clr);

endmodule

// File: rtl/osc_chain.sv
`timescale 1ns/1ps
module osc_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              run_en,
    input  logic              hold_clr,
    output logic [STAGES-1:0] taps,
    output logic [STAGES-1:0] rise,
    output logic              sec_tick
);

    localparam int TOP = STAGES - 1;

    logic              adv;
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] cnt_nxt;

    assign adv     = run_en & osc_tick;
    assign cnt_nxt = cnt_q + 1'b1;
    // a stage rises exactly where the increment sets a bit that was clear
    assign rise    = adv ? (cnt_nxt & ~cnt_q) : '0;
    assign taps    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= rise[TOP];
            if (hold_clr) begin
                cnt_q <= '0;
            end else if (adv) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R2: one step per oscillator tick in run
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && osc_tick && !hold_clr) |=> (cnt_q == STAGES'($past(cnt_q) + 1'b1)));

    // R4: stopped chain keeps its value
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !hold_clr) |=> $stable(cnt_q));

    // R10: one-clock tick, coinciding with a set top stage
    p_sec_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
    p_sec_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> cnt_q[TOP]);

endmodule

// File: rtl/osc_rate_mux.sv
`timescale 1ns/1ps
module osc_rate_mux #(
    parameter int STAGES    = 15,
    parameter int RS_W      = 4,
    parameter int FAST_CODE = 3,
    parameter int FAST_TAP  = 1,
    parameter int LOW_TAP   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RS_W-1:0]   rate_sel,
    input  logic              sq_en,
    input  logic              pi_en,
    input  logic [STAGES-1:0] taps,
    input  logic [STAGES-1:0] rise,
    output logic              sq_out,
    output logic              pi_pulse
);

    localparam int NCODES = 1 << RS_W;

    logic [NCODES-1:0] code_tap;
    logic [NCODES-1:0] code_rise;
    logic              sel_tap;
    logic              sel_rise;
    logic              unused_inputs;

    // code 0: no tap; codes below FAST_CODE: low-rate pair; rest: fast ladder
    for (genvar g = 0; g < NCODES; g++) begin : g_code
        localparam int IDX = (g == 0) ? -1 :
                             (g < FAST_CODE) ? (LOW_TAP + g - 1) :
                             (FAST_TAP + g - FAST_CODE);
        if (IDX >= 0 && IDX < STAGES) begin : g_tap
            assign code_tap[g]  = taps[IDX];
            assign code_rise[g] = rise[IDX];
        end else begin : g_none
            assign code_tap[g]  = 1'b0;
            assign code_rise[g] = 1'b0;
        end
    end

    assign unused_inputs = ^{taps, rise};
    assign sel_tap  = code_tap[rate_sel];
    assign sel_rise = code_rise[rate_sel];
    assign sq_out   = sq_en & sel_tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pi_pulse <= 1'b0;
        end else begin
            pi_pulse <= pi_en & sel_rise;
        end
    end

    // R8: square wave blocked by its enable
    p_sq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |-> !sq_out);

    // R9: pulse only when enabled the clock before, and one clock wide
    p_pulse_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pi_pulse |-> $past(pi_en));
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pi_pulse |=> !pi_pulse);

    // R7: code 0 yields no event and no square wave
    p_code0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !pi_pulse);
    p_code0_sq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> !sq_out);

endmodule

// File: rtl/osc_divider.sv
`timescale 1ns/1ps
module osc_divider #(
    parameter int STAGES = 15,
    parameter int RS_W   = 4,
    parameter int DV_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            osc_tick,
    input  logic [DV_W-1:0] dv_ctl,
    input  logic [RS_W-1:0] rate_sel,
    input  logic            sq_en,
    input  logic            pi_en,
    output logic            sq_out,
    output logic            pi_pulse,
    output logic            sec_tick
);

    logic              run_en;
    logic              hold_clr;
    logic [STAGES-1:0] taps;
    logic [STAGES-1:0] rise;

    osc_ctrl_fsm #(
        .DV_W (DV_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dv_ctl   (dv_ctl),
        .run_en   (run_en),
        .hold_clr (hold_clr)
    );

    osc_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .run_en   (run_en),
        .hold_clr (hold_clr),
        .taps     (taps),
        .rise     (rise),
        .sec_tick (sec_tick)
    );

    osc_rate_mux #(
        .STAGES (STAGES),
        .RS_W   (RS_W)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .sq_en    (sq_en),
        .pi_en    (pi_en),
        .taps     (taps),
        .rise     (rise),
        .sq_out   (sq_out),
        .pi_pulse (pi_pulse)
    );

    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pi_pulse && !sec_tick));

endmodule

// File: tb/sim_osc_divider.sv
`timescale 1ns/1ps
module sim_osc_divider;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [2:0] dv_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       sq_en = 1'b0;
    logic       pi_en = 1'b0;
    logic       sq_out;
    logic       pi_pulse;
    logic       sec_tick;

    int total = 0;
    int bad = 0;
    int pi_cnt = 0;
    int sec_cnt = 0;
    int sq_rise = 0;
    logic sq_prev = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_divider u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .dv_ctl   (dv_ctl),
        .rate_sel (rate_sel),
        .sq_en    (sq_en),
        .pi_en    (pi_en),
        .sq_out   (sq_out),
        .pi_pulse (pi_pulse),
        .sec_tick (sec_tick)
    );

    // event monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (pi_pulse) pi_cnt = pi_cnt + 1;
        if (sec_tick) sec_cnt = sec_cnt + 1;
        if (sq_out && !sq_prev) sq_rise = sq_rise + 1;
        sq_prev = sq_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk);
        pi_cnt = 0;
        sec_cnt = 0;
        sq_rise = 0;
        sq_prev = sq_out;
    endtask

    task automatic set_dv(input logic [2:0] v);
        @(negedge clk);
        dv_ctl = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic restart(input logic [3:0] code);
        set_dv(3'b110);
        @(negedge clk);
        rate_sel = code;
        set_dv(3'b010);
        clear_counts();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(sq_out == 1'b0, "R1 sq_out", int'(sq_out), 0);
        check(pi_pulse == 1'b0, "R1 pi_pulse", int'(pi_pulse), 0);
        check(sec_tick == 1'b0, "R1 sec_tick", int'(sec_tick), 0);
    endtask

    task automatic t_held();
        sq_en = 1'b1; pi_en = 1'b1; rate_sel = 4'd3;
        set_dv(3'b110);
        clear_counts();
        ticks(40);
        check(pi_cnt == 0, "R3 hold 110 pulses", pi_cnt, 0);
        check(sq_rise == 0 && sq_out == 1'b0, "R3 hold 110 square", sq_rise, 0);
        set_dv(3'b111);
        clear_counts();
        ticks(40);
        check(pi_cnt == 0, "R3 hold 111 pulses", pi_cnt, 0);
        check(sq_rise == 0 && sq_out == 1'b0, "R3 hold 111 square", sq_rise, 0);
    endtask

    task automatic t_run_fast();
        restart(4'd3);
        ticks(64);
        check(pi_cnt == 16, "R5 R2 code3 pulses", pi_cnt, 16);
        check(sq_rise == 16, "R8 code3 square edges", sq_rise, 16);
    endtask

    task automatic t_gates();
        @(negedge clk); pi_en = 1'b0; sq_en = 1'b1;
        restart(4'd3);
        ticks(32);
        check(pi_cnt == 0, "R9 pi_en low pulses", pi_cnt, 0);
        check(sq_rise == 8, "R8 sq_en high edges", sq_rise, 8);
        @(negedge clk); pi_en = 1'b1; sq_en = 1'b0;
        clear_counts();
        ticks(32);
        check(sq_rise == 0 && sq_out == 1'b0, "R8 sq_en low", sq_rise, 0);
        check(pi_cnt == 8, "R9 pi_en high pulses", pi_cnt, 8);
        @(negedge clk); sq_en = 1'b1;
    endtask

    task automatic t_rs_change();
        restart(4'd3);
        ticks(10);
        @(negedge clk); rate_sel = 4'd4;
        clear_counts();
        ticks(18);
        check(pi_cnt == 3, "R11 code change keeps chain", pi_cnt, 3);
    endtask

    task automatic t_code0();
        restart(4'd0);
        ticks(64);
        check(pi_cnt == 0, "R7 code0 pulses", pi_cnt, 0);
        check(sq_rise == 0 && sq_out == 1'b0, "R7 code0 square", sq_rise, 0);
    endtask

    task automatic t_slow();
        restart(4'd1);
        ticks(512);
        check(pi_cnt == 4, "R6 code1 pulses", pi_cnt, 4);
        restart(4'd2);
        ticks(512);
        check(pi_cnt == 2, "R6 code2 pulses", pi_cnt, 2);
    endtask

    task automatic t_second();
        restart(4'd15);
        ticks(16383);
        check(sec_cnt == 0, "R10 no tick before 16384", sec_cnt, 0);
        check(pi_cnt == 1, "R5 code15 pulses", pi_cnt, 1);
        ticks(1);
        check(sec_cnt == 1, "R10 first tick at 16384", sec_cnt, 1);
    endtask

    task automatic t_off();
        restart(4'd3);
        ticks(3);
        check(sq_out == 1'b1, "R4 square high before stop", int'(sq_out), 1);
        set_dv(3'b000);
        clear_counts();
        ticks(20);
        check(sq_out == 1'b1 && sq_rise == 0, "R4 000 frozen square", int'(sq_out), 1);
        check(pi_cnt == 0, "R4 000 no pulses", pi_cnt, 0);
        set_dv(3'b101);
        clear_counts();
        ticks(20);
        check(pi_cnt == 0 && sq_out == 1'b1, "R4 101 frozen", pi_cnt, 0);
        set_dv(3'b010);
        clear_counts();
        ticks(3);
        check(pi_cnt == 1, "R4 resume from frozen value", pi_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_held();
        t_run_fast();
        t_gates();
        t_rs_change();
        t_code0();
        t_slow();
        t_second();
        t_off();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule